// File: doc/BRIEF.md
# UART register file with watermark interrupts

This block is the software-facing half of a serial port. A 32-bit register bus writes bytes into a transmit queue and reads bytes out of a receive queue. It also writes and reads control, interrupt-enable and divisor words. A byte-wide ready/valid stream on each side connects the queues to a separate serializer, which is not part of this block. The divisor is held here and driven out on its own port for the baud generator.

Each control word carries a three-bit watermark count. The pending word is computed from those counts and the queue occupancy; it is not stored. A single level-sensitive interrupt line combines the enable bits with the receive queue state. Bus reads return data combinationally in the same cycle as the request. A receive-data read removes the byte on the clock edge that ends the access.

Top module: `uart_regfile`

## Requirements
- R1: An access takes effect only when all four byte strobes are set. Register offsets are 0x00 transmit data, 0x04 receive data, 0x08 transmit control, 0x0C receive control, 0x10 enable, 0x14 pending and 0x18 divisor. Any other offset, or any partial-strobe access, reads as zero and causes no write and no queue pop.
- R2: A write to offset 0x00 appends write-data bits 7:0 to the transmit queue. The queue presents its bytes on `tx_data`, oldest first, with `tx_valid` high while it is not empty. An entry leaves the queue on a cycle where `tx_valid` and `tx_ready` are both high.
- R3: A write to offset 0x00 while the 8-entry transmit queue is full is dropped, and the queue contents and order are unchanged.
- R4: A read of offset 0x00 returns bit 31 set while the transmit queue is full and all other bits zero. Bit 31 clears once one entry has drained.
- R5: A read of offset 0x04 with the receive queue not empty returns the oldest byte in bits 7:0 with all other bits zero, and removes that byte.
- R6: A read of offset 0x04 with the receive queue empty returns 0x80000000 and leaves the queue unchanged.
- R7: `rx_ready` is low while the 8-entry receive queue is full, and a byte offered in that state is lost.
- R8: Pending bit 1 is set while the receive occupancy is strictly greater than bits 18:16 of receive control. Pending bit 0 is set while bits 18:16 of transmit control are nonzero. All other pending bits read zero.
- R9: `irq` is high when enable bit 0 is set, or when enable bit 1 is set and the receive queue holds at least one byte. It follows every enable write, receive push and receive pop in the next cycle.
- R10: Reset clears both control words, the enable bits and the divisor. It empties both queues, so `tx_valid` and `irq` are low, `rx_ready` is high and pending reads zero.
- R11: Both control words and the divisor read back the last full 32-bit value written, and the divisor appears on `baud_div`. Enable reads back bits 1:0 of its last write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Access request |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_strb | input | 4 | Byte strobes; only 4'hF is honoured |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| irq | output | 1 | Interrupt line |
| tx_data | output | 8 | Oldest transmit byte |
| tx_valid | output | 1 | Transmit queue not empty |
| tx_ready | input | 1 | Serializer takes the byte |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | Received byte present |
| rx_ready | output | 1 | Receive queue has room |
| baud_div | output | 32 | Stored divisor |

## Verification
A wrong queue count shows up at once in three places: the full flag in transmit data, `tx_valid`/`rx_ready`, and the receive watermark pending bit. A wrong pointer shows up as a wrong byte on the next read or the next stream handshake. Bytes are therefore checked in order, from fill to drain. The order is checked across the full boundary, so a dropped overflow byte that leaked into the queue appears as an extra entry after the drain. Interrupt faults show up one cycle after the enable write or the queue change that should move the line.

// File: rtl/uart_regfile.sv
module uart_regfile #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_strb,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic [7:0]        tx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  input  logic [7:0]        rx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  output logic [31:0]       baud_div
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int WM_LSB = 16;
  localparam int WM_W   = 3;
  localparam logic [ADDR_W-1:0] A_TXD = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] A_RXD = ADDR_W'('h04);
  localparam logic [ADDR_W-1:0] A_TXC = ADDR_W'('h08);
  localparam logic [ADDR_W-1:0] A_RXC = ADDR_W'('h0C);
  localparam logic [ADDR_W-1:0] A_IE  = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] A_IP  = ADDR_W'('h14);
  localparam logic [ADDR_W-1:0] A_DIV = ADDR_W'('h18);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [31:0] txctrl, rxctrl, div_q;
  logic [1:0]  ie;

  logic [7:0]    tx_mem [DEPTH];
  logic [PW-1:0] tx_wp, tx_rp;
  logic [CW-1:0] tx_cnt;
  logic [7:0]    rx_mem [DEPTH];
  logic [PW-1:0] rx_wp, rx_rp;
  logic [CW-1:0] rx_cnt;

  wire wr_ok = bus_sel &  bus_wr & (bus_strb == 4'hF);
  wire rd_ok = bus_sel & ~bus_wr & (bus_strb == 4'hF);

  wire tx_full  = (tx_cnt == FULL);
  wire tx_push  = wr_ok && (bus_addr == A_TXD) && !tx_full;
  wire tx_pop   = tx_valid && tx_ready;
  wire rx_full  = (rx_cnt == FULL);
  wire rx_empty = (rx_cnt == '0);
  wire rx_push  = rx_valid && rx_ready;
  wire rx_pop   = rd_ok && (bus_addr == A_RXD) && !rx_empty;

  wire tx_wm_hit = (txctrl[WM_LSB +: WM_W] != '0);
  wire rx_wm_hit = int'(rx_cnt) > int'(rxctrl[WM_LSB +: WM_W]);

  assign tx_valid = (tx_cnt != '0);
  assign tx_data  = tx_mem[tx_rp];
  assign rx_ready = !rx_full;
  assign baud_div = div_q;
  assign irq      = ie[0] | (ie[1] & !rx_empty);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txctrl <= '0;
      rxctrl <= '0;
      div_q  <= '0;
      ie     <= '0;
    end else if (wr_ok) begin
      case (bus_addr)
        A_TXC:   txctrl <= bus_wdata;
        A_RXC:   rxctrl <= bus_wdata;
        A_DIV:   div_q  <= bus_wdata;
        A_IE:    ie     <= bus_wdata[1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= bus_wdata[7:0];
    if (rx_push) rx_mem[rx_wp] <= rx_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp  <= '0;
      tx_rp  <= '0;
      tx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= (tx_wp == LAST) ? '0 : tx_wp + 1'b1;
      if (tx_pop)  tx_rp <= (tx_rp == LAST) ? '0 : tx_rp + 1'b1;
      if (tx_push && !tx_pop)      tx_cnt <= tx_cnt + 1'b1;
      else if (tx_pop && !tx_push) tx_cnt <= tx_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_wp  <= '0;
      rx_rp  <= '0;
      rx_cnt <= '0;
    end else begin
      if (rx_push) rx_wp <= (rx_wp == LAST) ? '0 : rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= (rx_rp == LAST) ? '0 : rx_rp + 1'b1;
      if (rx_push && !rx_pop)      rx_cnt <= rx_cnt + 1'b1;
      else if (rx_pop && !rx_push) rx_cnt <= rx_cnt - 1'b1;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_ok) begin
      case (bus_addr)
        A_TXD:   bus_rdata = {tx_full, 31'b0};
        A_RXD:   bus_rdata = rx_empty ? 32'h8000_0000 : {24'b0, rx_mem[rx_rp]};
        A_TXC:   bus_rdata = txctrl;
        A_RXC:   bus_rdata = rxctrl;
        A_IE:    bus_rdata = {30'b0, ie};
        A_IP:    bus_rdata = {30'b0, rx_wm_hit, tx_wm_hit};
        A_DIV:   bus_rdata = div_q;
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/uart_regfile_chk.sv
module uart_regfile_chk #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 5
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         bus_sel,
  input logic                         bus_wr,
  input logic [ADDR_W-1:0]            bus_addr,
  input logic [3:0]                   bus_strb,
  input logic [31:0]                  bus_rdata,
  input logic                         irq,
  input logic                         tx_valid,
  input logic                         tx_ready,
  input logic                         rx_valid,
  input logic                         rx_ready,
  input logic [1:0]                   ie,
  input logic [$clog2(DEPTH+1)-1:0]   tx_cnt,
  input logic [$clog2(DEPTH+1)-1:0]   rx_cnt
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  wire full_acc = bus_sel && (bus_strb == 4'hF);
  wire wr_txd   = full_acc && bus_wr && (bus_addr == '0);
  wire rd_rxd   = full_acc && !bus_wr && (bus_addr == ADDR_W'('h04));

  assert_tx_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= FULL);

  assert_tx_drop_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt == FULL && wr_txd && !(tx_valid && tx_ready)) |=> (tx_cnt == FULL));

  assert_rx_pop_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt != '0 && rd_rxd && !(rx_valid && rx_ready)) |=> (rx_cnt == CW'($past(rx_cnt) - 1'b1)));

  assert_rx_empty_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt == '0 && rd_rxd) |-> (bus_rdata == 32'h8000_0000));

  assert_rx_full_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt == FULL) |-> !rx_ready);

  assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ie == 2'b00) |-> !irq);

  assert_irq_tx_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ie[0] |-> irq);
endmodule

bind uart_regfile uart_regfile_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_strb(bus_strb), .bus_rdata(bus_rdata),
  .irq(irq), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .ie(ie),
  .tx_cnt(tx_cnt), .rx_cnt(rx_cnt)
);

// File: tb/uart_regfile_tb_top.sv
module uart_regfile_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [3:0]  bus_strb = 4'hF;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, tx_valid, rx_ready;
  logic        tx_ready = 1'b0, rx_valid = 1'b0;
  logic [7:0]  tx_data, rx_data = '0;
  logic [31:0] baud_div;

  int nchk = 0;
  int nfail = 0;

  always #4 clk = ~clk;

  uart_regfile #(.DEPTH(8), .ADDR_W(5)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_strb(bus_strb), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .baud_div(baud_div)
  );

  // {read(1)/write(0), addr[4:0], wdata[31:0], expect[31:0]}
  localparam int NV = 16;
  localparam logic [69:0] VEC [NV] = '{
    {1'b1, 5'h08, 32'h0,          32'h0},
    {1'b0, 5'h08, 32'h0007_0000,  32'h0},
    {1'b1, 5'h08, 32'h0,          32'h0007_0000},
    {1'b1, 5'h14, 32'h0,          32'h1},
    {1'b0, 5'h0C, 32'h0002_0000,  32'h0},
    {1'b1, 5'h0C, 32'h0,          32'h0002_0000},
    {1'b1, 5'h14, 32'h0,          32'h1},
    {1'b0, 5'h18, 32'hCAFE_1234,  32'h0},
    {1'b1, 5'h18, 32'h0,          32'hCAFE_1234},
    {1'b0, 5'h10, 32'hFFFF_FFFF,  32'h0},
    {1'b1, 5'h10, 32'h0,          32'h3},
    {1'b1, 5'h1C, 32'h0,          32'h0},
    {1'b0, 5'h1C, 32'h1234_5678,  32'h0},
    {1'b1, 5'h1C, 32'h0,          32'h0},
    {1'b1, 5'h04, 32'h0,          32'h8000_0000},
    {1'b1, 5'h00, 32'h0,          32'h0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic bwrite(input logic [4:0] a, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_strb = s;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0; bus_strb = 4'hF;
  endtask

  task automatic bread(input logic [4:0] a, input logic [3:0] s, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_strb = s;
    #1 d = bus_rdata;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_strb = 4'hF;
  endtask

  task automatic rx_push(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b;
    @(posedge clk); #1;
    rx_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(8 * 200000);
    nfail++;
    $display("FAIL watchdog act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 irq", {31'b0, irq}, 32'h0);
    check("R10 tx_valid", {31'b0, tx_valid}, 32'h0);
    check("R10 rx_ready", {31'b0, rx_ready}, 32'h1);
    check("R10 baud_div", baud_div, 32'h0);

    // Table: R11 readback, R8 pending, R1 unmapped, R6 empty read, R4 not full
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][69]) begin
        bread(VEC[i][68:64], 4'hF, d);
        check($sformatf("R1/R4/R6/R8/R11 vector %0d", i), d, VEC[i][31:0]);
      end else begin
        bwrite(VEC[i][68:64], VEC[i][63:32], 4'hF);
      end
    end
    check("R11 baud_div port", baud_div, 32'hCAFE_1234);
    check("R9 irq from tx enable", {31'b0, irq}, 32'h1);

    // R10 second reset clears stored words
    do_reset();
    bread(5'h08, 4'hF, d); check("R10 txctrl", d, 32'h0);
    bread(5'h0C, 4'hF, d); check("R10 rxctrl", d, 32'h0);
    bread(5'h10, 4'hF, d); check("R10 enable", d, 32'h0);
    bread(5'h14, 4'hF, d); check("R10 pending", d, 32'h0);
    bread(5'h18, 4'hF, d); check("R10 divisor", d, 32'h0);
    check("R10 irq after reset", {31'b0, irq}, 32'h0);

    // R1 partial strobes are ignored
    bwrite(5'h00, 32'h0000_00EE, 4'h1);
    check("R1 partial tx write", {31'b0, tx_valid}, 32'h0);
    bwrite(5'h18, 32'h0000_0055, 4'h3);
    check("R1 partial div write", baud_div, 32'h0);

    // R2/R3/R4 transmit path
    for (int i = 0; i < 8; i++) bwrite(5'h00, 32'hFFFF_FF00 | (32'hA1 + i), 4'hF);
    bread(5'h00, 4'hF, d); check("R4 full flag", d, 32'h8000_0000);
    check("R2 head byte", {24'b0, tx_data}, 32'hA1);
    bwrite(5'h00, 32'h0000_0055, 4'hF);
    check("R3 head after overflow", {24'b0, tx_data}, 32'hA1);
    @(negedge clk); tx_ready = 1'b1;
    @(posedge clk); #1 tx_ready = 1'b0;
    bread(5'h00, 4'hF, d); check("R4 full cleared after drain", d, 32'h0);
    for (int i = 1; i < 8; i++) begin
      @(negedge clk);
      check($sformatf("R2/R3 tx order %0d", i), {23'b0, tx_valid, tx_data}, 32'h100 | (32'hA1 + i));
      tx_ready = 1'b1;
      @(posedge clk); #1 tx_ready = 1'b0;
    end
    @(negedge clk);
    check("R3 dropped byte absent", {31'b0, tx_valid}, 32'h0);

    // R5..R9 receive path
    bwrite(5'h10, 32'h2, 4'hF);
    bwrite(5'h0C, 32'h0002_0000, 4'hF);
    check("R9 idle with rx enable", {31'b0, irq}, 32'h0);
    rx_push(8'h11);
    check("R9 irq on first rx byte", {31'b0, irq}, 32'h1);
    rx_push(8'h22);
    bread(5'h14, 4'hF, d); check("R8 two bytes not above mark", d, 32'h0);
    rx_push(8'h33);
    bread(5'h14, 4'hF, d); check("R8 three bytes above mark", d, 32'h2);
    for (int i = 4; i <= 8; i++) rx_push(8'(i * 8'h11));
    check("R7 ready low when full", {31'b0, rx_ready}, 32'h0);
    rx_push(8'h99);
    bread(5'h04, 4'h7, d); check("R1 partial rx read", d, 32'h0);
    for (int i = 1; i <= 8; i++) begin
      bread(5'h04, 4'hF, d);
      check($sformatf("R5/R7 rx order %0d", i), d, 32'(i * 8'h11));
    end
    bread(5'h04, 4'hF, d); check("R6 empty after drain", d, 32'h8000_0000);
    bread(5'h04, 4'hF, d); check("R6 empty read repeat", d, 32'h8000_0000);
    check("R9 irq drops when empty", {31'b0, irq}, 32'h0);
    check("R7 ready back high", {31'b0, rx_ready}, 32'h1);
    bwrite(5'h10, 32'h1, 4'hF);
    check("R9 tx enable raises irq", {31'b0, irq}, 32'h1);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule